// File: doc/BRIEF.md
# CSR Access Permission Gate

This block decides, for one control and status register access by a hart that implements the hypervisor extension, whether the access may proceed or must trap. It looks at the upper four bits of the 12-bit register address, which encode the lowest privilege allowed to touch the register and whether it is read-only. It combines these with the write intent, the current privilege mode, the virtualization bit and two flags that say whether the supervisor and hypervisor extensions are fitted. It then returns exactly one of three verdicts: allow, illegal-instruction trap or virtual-instruction trap.

Supervisor mode with virtualization off is ranked at the hypervisor level for the comparison. Any failed access to a hypervisor-level register from a lower rank is reported as a virtual-instruction trap rather than an illegal one. A second request kind covers instructions that may only run with virtualization off. The verdict is combinational by default. A parameter adds one register stage so that the verdict can be placed on a pipeline boundary.

Top module: `csr_gate`

## Requirements
- R1: The required level is taken from address bits [9:8]. The current mode on `mode_i` uses the same encoding: 0 user, 1 supervisor, 2 hypervisor rank, 3 machine. Levels are compared as unsigned 2-bit values. Address bits [7:0] have no effect on the verdict.
- R2: When the required level is 2 and `has_h_i` is 0, the verdict is illegal-instruction. This holds for every mode, virtualization state and write flag, and this check overrides all others.
- R3: When the required level is 1 and `has_s_i` is 0, the verdict is illegal-instruction, whatever the mode.
- R4: The effective rank is 2 when `mode_i` is 1 and `virt_i` is 0. Otherwise it equals `mode_i`.
- R5: A register whose address bits [11:10] are 2'b11 is read-only. A write to it (`wr_i` = 1) is a violation. A read of it is not.
- R6: An effective rank below the required level is a violation. With no extension fault and no violation, the verdict is allow.
- R7: A violation on a register whose required level is 2 gives a virtual-instruction trap. A violation at any other required level gives an illegal-instruction trap.
- R8: With `novirt_req_i` = 1, the address, write flag and extension flags are ignored. The verdict is a virtual-instruction trap when `virt_i` = 1 and allow when `virt_i` = 0.
- R9: With `req_valid_i` = 0, all three outputs are 0. At no time is more than one output high.
- R10: With `REG_OUT` = 1, the outputs show the verdict for the inputs sampled at the previous rising clock edge, and reset holds them at 0. With `REG_OUT` = 0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used only when `REG_OUT` = 1 |
| rst_ni | input | 1 | Asynchronous active-low reset of the output stage |
| req_valid_i | input | 1 | A request is present this cycle |
| novirt_req_i | input | 1 | The request is a virtualization-off instruction check rather than a register access |
| csr_addr_i | input | 12 | Register address |
| wr_i | input | 1 | The access intends to write |
| mode_i | input | 2 | Current privilege mode |
| virt_i | input | 1 | Virtualization bit |
| has_s_i | input | 1 | Supervisor extension present |
| has_h_i | input | 1 | Hypervisor extension present |
| allow_o | output | 1 | Access may proceed |
| ill_o | output | 1 | Raise illegal-instruction trap |
| vir_o | output | 1 | Raise virtual-instruction trap |

## Verification
Several properties are checked on every cycle. The outputs are mutually exclusive and stay quiet when no request is valid. A missing hypervisor extension always yields an illegal trap. A write to a read-only register is never allowed. The virtualization-off check traps whenever V is set. In registered mode, the outputs repeat the previous cycle's verdict. Only the bench's scenarios can show that every combination of level, access bits, write flag, mode, V and extension flags maps to the correct one of the three verdicts. They also show that the low address bits are ignored and that reset clears the registered stage.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

  typedef enum logic [1:0] {
    LVL_U = 2'd0,
    LVL_S = 2'd1,
    LVL_H = 2'd2,
    LVL_M = 2'd3
  } priv_lvl_e;

  typedef struct packed {
    logic allow;
    logic ill;
    logic vir;
  } verdict_t;

  localparam verdict_t VERD_QUIET = '{allow: 1'b0, ill: 1'b0, vir: 1'b0};
  localparam verdict_t VERD_ALLOW = '{allow: 1'b1, ill: 1'b0, vir: 1'b0};
  localparam verdict_t VERD_ILL   = '{allow: 1'b0, ill: 1'b1, vir: 1'b0};
  localparam verdict_t VERD_VIR   = '{allow: 1'b0, ill: 1'b0, vir: 1'b1};

  // Supervisor with virtualization off competes at the hypervisor rank.
  function automatic priv_lvl_e eff_rank(priv_lvl_e mode, logic virt);
    if (mode == LVL_S && !virt) return LVL_H;
    return mode;
  endfunction

  function automatic logic rank_short(priv_lvl_e have, priv_lvl_e need);
    return 2'(have) < 2'(need);
  endfunction

  function automatic logic ext_absent(priv_lvl_e need, logic has_s, logic has_h);
    return ((need == LVL_H) && !has_h) || ((need == LVL_S) && !has_s);
  endfunction

  function automatic verdict_t fail_kind(priv_lvl_e need);
    return (need == LVL_H) ? VERD_VIR : VERD_ILL;
  endfunction

endpackage

// File: rtl/csr_gate_field.sv
module csr_gate_field
  import csr_gate_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output priv_lvl_e         need_o,
  output logic              ro_o
);
  localparam int ACC_HI = ADDR_W - 1;
  localparam int ACC_LO = ADDR_W - 2;
  localparam int LVL_HI = ADDR_W - 3;
  localparam int LVL_LO = ADDR_W - 4;

  wire unused_addr_lo = ^addr_i[LVL_LO-1:0];

  assign need_o = priv_lvl_e'(addr_i[LVL_HI:LVL_LO]);
  assign ro_o   = &addr_i[ACC_HI:ACC_LO];
endmodule

// File: rtl/csr_gate_rank.sv
module csr_gate_rank
  import csr_gate_pkg::*;
(
  input  priv_lvl_e mode_i,
  input  logic      virt_i,
  output priv_lvl_e eff_o
);
  assign eff_o = eff_rank(mode_i, virt_i);
endmodule

// File: rtl/csr_gate_judge.sv
module csr_gate_judge
  import csr_gate_pkg::*;
(
  input  logic      valid_i,
  input  logic      novirt_i,
  input  priv_lvl_e need_i,
  input  logic      ro_i,
  input  logic      wr_i,
  input  priv_lvl_e eff_i,
  input  logic      virt_i,
  input  logic      has_s_i,
  input  logic      has_h_i,
  output logic      ext_missing_o,
  output logic      viol_o,
  output verdict_t  verd_o
);
  always_comb begin
    ext_missing_o = ext_absent(need_i, has_s_i, has_h_i);
    viol_o        = (wr_i && ro_i) || rank_short(eff_i, need_i);
    verd_o        = VERD_QUIET;
    if (valid_i) begin
      if (novirt_i)           verd_o = virt_i ? VERD_VIR : VERD_ALLOW;
      else if (ext_missing_o) verd_o = VERD_ILL;
      else if (viol_o)        verd_o = fail_kind(need_i);
      else                    verd_o = VERD_ALLOW;
    end
  end
endmodule

// File: rtl/csr_gate.sv
module csr_gate
  import csr_gate_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter bit REG_OUT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              novirt_req_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              wr_i,
  input  logic [1:0]        mode_i,
  input  logic              virt_i,
  input  logic              has_s_i,
  input  logic              has_h_i,
  output logic              allow_o,
  output logic              ill_o,
  output logic              vir_o
);
  priv_lvl_e fld_need;
  logic      fld_ro;
  priv_lvl_e eff_lvl;
  logic      ext_missing;
  logic      viol;
  verdict_t  pre_verd;
  verdict_t  out_verd;
  logic      pre_allow, pre_ill, pre_vir;

  csr_gate_field #(.ADDR_W(ADDR_W)) u_field (
    .addr_i (csr_addr_i),
    .need_o (fld_need),
    .ro_o   (fld_ro)
  );

  csr_gate_rank u_rank (
    .mode_i (priv_lvl_e'(mode_i)),
    .virt_i (virt_i),
    .eff_o  (eff_lvl)
  );

  csr_gate_judge u_judge (
    .valid_i       (req_valid_i),
    .novirt_i      (novirt_req_i),
    .need_i        (fld_need),
    .ro_i          (fld_ro),
    .wr_i          (wr_i),
    .eff_i         (eff_lvl),
    .virt_i        (virt_i),
    .has_s_i       (has_s_i),
    .has_h_i       (has_h_i),
    .ext_missing_o (ext_missing),
    .viol_o        (viol),
    .verd_o        (pre_verd)
  );

  assign pre_allow = pre_verd.allow;
  assign pre_ill   = pre_verd.ill;
  assign pre_vir   = pre_verd.vir;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_verd <= VERD_QUIET;
        else         out_verd <= pre_verd;
      end
    end else begin : g_comb
      wire unused_clk = clk_i ^ rst_ni;
      assign out_verd = pre_verd;
    end
  endgenerate

  wire unused_dbg = ^{ext_missing, viol, eff_lvl};

  assign allow_o = out_verd.allow;
  assign ill_o   = out_verd.ill;
  assign vir_o   = out_verd.vir;
endmodule

// File: rtl/csr_gate_chk.sv
module csr_gate_chk #(
  parameter bit REG_OUT = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       novirt_req_i,
  input logic [3:0] addr_hi,
  input logic       wr_i,
  input logic       virt_i,
  input logic       has_h_i,
  input logic       pre_allow,
  input logic       pre_ill,
  input logic       pre_vir,
  input logic       allow_o,
  input logic       ill_o,
  input logic       vir_o
);
  AST_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({allow_o, ill_o, vir_o}) && $onehot0({pre_allow, pre_ill, pre_vir})); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(pre_allow || pre_ill || pre_vir)); // R9

  AST_HEXT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !novirt_req_i && addr_hi[1:0] == 2'b10 && !has_h_i) |-> pre_ill); // R2

  AST_RO_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !novirt_req_i && wr_i && addr_hi[3:2] == 2'b11) |-> !pre_allow); // R5

  AST_NOVIRT_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && novirt_req_i) |-> (pre_vir == virt_i) && (pre_allow == !virt_i)); // R8

  generate
    if (REG_OUT) begin : g_pipe_chk
      AST_PIPE_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ({allow_o, ill_o, vir_o} == $past({pre_allow, pre_ill, pre_vir}))); // R10
    end
  endgenerate
endmodule

bind csr_gate csr_gate_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .novirt_req_i (novirt_req_i),
  .addr_hi      (csr_addr_i[ADDR_W-1:ADDR_W-4]),
  .wr_i         (wr_i),
  .virt_i       (virt_i),
  .has_h_i      (has_h_i),
  .pre_allow    (pre_allow),
  .pre_ill      (pre_ill),
  .pre_vir      (pre_vir),
  .allow_o      (allow_o),
  .ill_o        (ill_o),
  .vir_o        (vir_o)
);

// File: tb/csr_gate_bench.sv
module csr_gate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        novirt = 1'b0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        virt = 1'b0;
  logic        hs = 1'b1;
  logic        hh = 1'b1;
  logic        c_allow, c_ill, c_vir;
  logic        q_allow, q_ill, q_vir;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_gate #(.ADDR_W(12), .REG_OUT(1'b0)) u_csr_gate (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .novirt_req_i(novirt),
    .csr_addr_i(addr), .wr_i(wr), .mode_i(mode), .virt_i(virt),
    .has_s_i(hs), .has_h_i(hh), .allow_o(c_allow), .ill_o(c_ill), .vir_o(c_vir)
  );

  csr_gate #(.ADDR_W(12), .REG_OUT(1'b1)) u_csr_gate_q (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .novirt_req_i(novirt),
    .csr_addr_i(addr), .wr_i(wr), .mode_i(mode), .virt_i(virt),
    .has_s_i(hs), .has_h_i(hh), .allow_o(q_allow), .ill_o(q_ill), .vir_o(q_vir)
  );

  // expected outputs as {allow, ill, vir}
  localparam logic [2:0] EXP_NONE = 3'b000;
  localparam logic [2:0] EXP_OK   = 3'b100;
  localparam logic [2:0] EXP_ILL  = 3'b010;
  localparam logic [2:0] EXP_VIR  = 3'b001;

  function automatic logic [2:0] model(logic [3:0] hi, logic w, logic [1:0] m,
                                       logic v, logic s_ok, logic h_ok);
    int need = int'(hi[1:0]);
    int have = (m == 2'd1 && !v) ? 2 : int'(m);
    if (need == 2 && !h_ok) return EXP_ILL;
    if (need == 1 && !s_ok) return EXP_ILL;
    if ((w && hi[3:2] == 2'b11) || have < need) return (need == 2) ? EXP_VIR : EXP_ILL;
    return EXP_OK;
  endfunction

  function automatic string rule_of(logic [3:0] hi, logic w, logic [1:0] m,
                                    logic v, logic s_ok, logic h_ok);
    int need = int'(hi[1:0]);
    int have = (m == 2'd1 && !v) ? 2 : int'(m);
    if (need == 2 && !h_ok) return "R2";
    if (need == 1 && !s_ok) return "R3";
    if (w && hi[3:2] == 2'b11) return "R5";
    if (have < need) return (need == 2) ? "R7" : "R6";
    if (m == 2'd1 && !v && need == 2) return "R4";
    return "R1";
  endfunction

  task automatic chk(string tag, logic [2:0] got, logic [2:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h wr=%0b mode=%0d v=%0b s=%0b h=%0b nv=%0b got=%b exp=%b",
               tag, addr, wr, mode, virt, hs, hh, novirt, got, exp);
    end
  endtask

  task automatic drv(logic vl, logic nv, logic [11:0] a, logic w, logic [1:0] m,
                     logic v, logic s_ok, logic h_ok);
    @(negedge clk);
    valid = vl; novirt = nv; addr = a; wr = w; mode = m; virt = v; hs = s_ok; hh = h_ok;
    #(CLK_PERIOD/4);
  endtask

  // combinational result now, registered result after the next rising edge
  task automatic chk_both(string tag, logic [2:0] exp);
    chk(tag, {c_allow, c_ill, c_vir}, exp);
    @(posedge clk); #1;
    chk({tag, "_r10_q"}, {q_allow, q_ill, q_vir}, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drv(1'b1, 1'b0, 12'h300, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1);
    @(posedge clk); #1;
    chk("R10 reset clears registered stage", {q_allow, q_ill, q_vir}, EXP_NONE);
    chk("R10 comb path live in reset", {c_allow, c_ill, c_vir}, EXP_OK);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_idle;
    for (int k = 0; k < 16; k++) begin
      drv(1'b0, k[0], {k[3:0], 8'h5A}, k[1], k[3:2], k[2], k[0], k[1]);
      chk_both("R9 idle quiet", EXP_NONE);
    end
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 1024; k++) begin
      logic [3:0] hi = k[3:0];
      logic w = k[4];
      logic [1:0] m = k[6:5];
      logic v = k[7];
      logic s_ok = k[8];
      logic h_ok = k[9];
      logic [7:0] lo = 8'(k * 37 + 11);
      drv(1'b1, 1'b0, {hi, lo}, w, m, v, s_ok, h_ok);
      chk_both(rule_of(hi, w, m, v, s_ok, h_ok), model(hi, w, m, v, s_ok, h_ok));
    end
  endtask

  task automatic t_low_bits;
    drv(1'b1, 1'b0, 12'h600, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1);
    chk_both("R1 low bits zero", EXP_VIR);
    drv(1'b1, 1'b0, 12'h6FF, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1);
    chk_both("R1 low bits ones", EXP_VIR);
  endtask

  task automatic t_corners;
    drv(1'b1, 1'b0, 12'h600, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1);
    chk_both("R4 hs-mode writes hyp csr", EXP_OK);
    drv(1'b1, 1'b0, 12'hE00, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0);
    chk_both("R2 no H ext from machine", EXP_ILL);
    drv(1'b1, 1'b0, 12'h100, 1'b0, 2'd3, 1'b1, 1'b0, 1'b1);
    chk_both("R3 no S ext from machine", EXP_ILL);
    drv(1'b1, 1'b0, 12'hF10, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1);
    chk_both("R5 write read-only machine csr", EXP_ILL);
    drv(1'b1, 1'b0, 12'hF10, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1);
    chk_both("R5 read read-only machine csr", EXP_OK);
    drv(1'b1, 1'b0, 12'hE80, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1);
    chk_both("R7 write read-only hyp csr", EXP_VIR);
    drv(1'b1, 1'b0, 12'h300, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1);
    chk_both("R6 hs-mode reads machine csr", EXP_ILL);
  endtask

  task automatic t_novirt;
    for (int k = 0; k < 16; k++) begin
      drv(1'b1, 1'b1, {k[3:0], 8'h3C}, k[0], k[2:1], k[3], k[1], k[2]);
      chk_both("R8 novirt check", k[3] ? EXP_VIR : EXP_OK);
    end
  endtask

  task automatic t_pipe;
    drv(1'b1, 1'b0, 12'h300, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1);
    chk("R10 comb same cycle", {c_allow, c_ill, c_vir}, EXP_ILL);
    @(posedge clk); #1;
    drv(1'b1, 1'b0, 12'h300, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1);
    chk("R10 registered holds prior verdict", {q_allow, q_ill, q_vir}, EXP_ILL);
    @(posedge clk); #1;
    chk("R10 registered takes new verdict", {q_allow, q_ill, q_vir}, EXP_OK);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_idle();
    t_sweep();
    t_low_bits();
    t_corners();
    t_novirt();
    t_pipe();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule